// File: doc/BRIEF.md
# Shared-Zone Crossing Interlock Controller

This block controls a single-acting turntable that two crossing conveyor axes share. One axis carries traffic in directions 12 and 21, the other in directions 34 and 43. On each scan tick the block reads the two turntable position switches, the per-axis zone-occupancy flags, the four per-direction crossing requests and a park selector. It then decides which axis may enter the shared zone, drives a green/red light pair for each of the four directions, and commands the turntable.

The arbitration uses a fixed order. The 34 axis is granted first whenever that is allowed, and the 12 axis comes second. Greens are then lit wherever they are permitted. An idle turntable is parked at the selected default position. A green is only shown once the turntable reports that it sits at that axis's position. If the inputs are physically incoherent, the block falls back to all-red and changes nothing else.

All outputs are registered. They update only on a clock edge where the scan tick is high.

Top module: `ilk_crossing_ctrl`

## Requirements
- R1: For every direction, `stop_o` is the bitwise complement of `go_o` at all times after reset. Bit order in both vectors is 0 = direction 12, 1 = direction 21, 2 = direction 34, 3 = direction 43.
- R2: The two directions of one axis show the same light: `go_o[1]` equals `go_o[0]`, and `go_o[3]` equals `go_o[2]`.
- R3: The green of an axis is lit only if that axis's position switch was active in the sampled scan and either the axis is granted or its occupancy flag was set.
- R4: The green of axis 12 and the green of axis 34 are never lit together.
- R5: With coherent inputs, an axis whose occupancy flag is set gets its green in that scan.
- R6: With coherent inputs, `rotate_o` = 1 (position 12) whenever axis 12 is granted or occupied. It is 0 (position 34) whenever axis 34 is granted or occupied.
- R7: The grants are mutually exclusive. An axis is granted only if it has a pending request on either of its directions and the other axis has no occupancy flag set.
- R8: Fixed priority applies. Axis 34 is granted whenever it has a pending request and axis 12 is not occupied. Axis 12 is granted only when it has a request, axis 34 is neither occupied nor requesting, or when axis 12 itself is occupied.
- R9: With coherent inputs, no grant and no occupancy, `rotate_o` follows `park12_i`: 1 parks at position 12 and 0 parks at position 34.
- R10: Greens are maximal. With coherent inputs, an axis shows green whenever its position switch is active and it is granted or occupied.
- R11: Inputs are incoherent when both position switches are active, or when an occupancy flag is set while its own position switch is inactive. In that case the block makes all lights red, clears both grants and keeps `rotate_o` unchanged.
- R12: Inputs are sampled on a rising clock edge with `tick_i` = 1, and the result appears on the outputs right after that edge. With `tick_i` = 0, every output holds.
- R13: A synchronous reset (`rst` high) sets every light to red, clears both grants and sets `rotate_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Scan-tick enable; outputs update only when high |
| at12_i | input | 1 | Turntable position switch, position 12 |
| at34_i | input | 1 | Turntable position switch, position 34 |
| occ12_i | input | 1 | A pallet of axis 12 occupies the shared zone |
| occ34_i | input | 1 | A pallet of axis 34 occupies the shared zone |
| dir_req_i | input | 4 | Crossing requests, bit 0 = 12, 1 = 21, 2 = 34, 3 = 43 |
| park12_i | input | 1 | Park selector: 1 = park at 12, 0 = park at 34 |
| go_o | output | 4 | Green lights, same bit order as `dir_req_i` |
| stop_o | output | 4 | Red lights, same bit order as `dir_req_i` |
| rotate_o | output | 1 | Turntable actuator: 1 = position 12, 0 = position 34 |
| grant12_o | output | 1 | Axis 12 is authorized to use the zone |
| grant34_o | output | 1 | Axis 34 is authorized to use the zone |

## Verification
The two functions that meet in one scan are the priority grant of axis 34 and the hold of axis 12 on a zone it already occupies. A second meeting point is the park decision against a fresh grant. The bench provokes both by sweeping every combination of switches, occupancy flags, requests and park selector in one scan each. This includes requests on both axes while a pallet of axis 12 is in the zone, and no requests at all under both park values. Each scan is judged against an independent model of R5 to R11, which also carries the turntable state across incoherent scans. A separate phase drops the tick while the inputs change, to confirm that every output holds.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    localparam int NUM_AXES      = 2;
    localparam int DIRS_PER_AXIS = 2;
    localparam int NUM_DIRS      = NUM_AXES * DIRS_PER_AXIS;

    // axis indices; position in vectors follows direction order 12,21,34,43
    localparam int AX12 = 0;
    localparam int AX34 = 1;

    typedef struct packed {
        logic [NUM_DIRS-1:0] go;
        logic [NUM_DIRS-1:0] stop;
        logic                rotate;
        logic [NUM_AXES-1:0] grant;
    } scan_out_t;

    // one flag per axis: any direction of that axis is requesting
    function automatic logic [NUM_AXES-1:0] axis_wants(logic [NUM_DIRS-1:0] req);
        logic [NUM_AXES-1:0] w;
        for (int ax = 0; ax < NUM_AXES; ax++) begin
            w[ax] = |req[ax*DIRS_PER_AXIS +: DIRS_PER_AXIS];
        end
        return w;
    endfunction

    // at most one position switch, and occupancy only at its own position
    function automatic logic inputs_coherent(logic [NUM_AXES-1:0] at,
                                             logic [NUM_AXES-1:0] occ);
        logic one_pos;
        one_pos = ((at & (at - NUM_AXES'(1))) == '0);
        return one_pos && ((occ & ~at) == '0);
    endfunction

endpackage

// File: rtl/ilk_arbiter.sv
module ilk_arbiter
    import ilk_pkg::*;
(
    input  logic [NUM_AXES-1:0] want,
    input  logic [NUM_AXES-1:0] occ,
    input  logic                coherent,
    output logic [NUM_AXES-1:0] grant
);
    // axis 34 wins first; axis 12 only if 34 is not granted
    always_comb begin
        grant       = '0;
        grant[AX34] = coherent & want[AX34] & ~occ[AX12];
        grant[AX12] = coherent & want[AX12] & ~occ[AX34] & ~grant[AX34];
    end
endmodule

// File: rtl/ilk_light_gate.sv
module ilk_light_gate
    import ilk_pkg::*;
(
    input  logic [NUM_AXES-1:0] at,
    input  logic [NUM_AXES-1:0] occ,
    input  logic [NUM_AXES-1:0] grant,
    input  logic                coherent,
    output logic [NUM_DIRS-1:0] go
);
    for (genvar ax = 0; ax < NUM_AXES; ax++) begin : g_axis
        logic axis_green;
        assign axis_green = coherent & at[ax] & (grant[ax] | occ[ax]);
        for (genvar d = 0; d < DIRS_PER_AXIS; d++) begin : g_dir
            assign go[ax*DIRS_PER_AXIS + d] = axis_green;
        end
    end
endmodule

// File: rtl/ilk_rotator.sv
module ilk_rotator
    import ilk_pkg::*;
(
    input  logic [NUM_AXES-1:0] occ,
    input  logic [NUM_AXES-1:0] grant,
    input  logic                coherent,
    input  logic                park12,
    input  logic                rot_q,
    output logic                rot_next
);
    always_comb begin
        if (!coherent)
            rot_next = rot_q;
        else if (grant[AX12] | occ[AX12])
            rot_next = 1'b1;
        else if (grant[AX34] | occ[AX34])
            rot_next = 1'b0;
        else
            rot_next = park12;
    end
endmodule

// File: rtl/ilk_crossing_ctrl.sv
module ilk_crossing_ctrl
    import ilk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic                at12_i,
    input  logic                at34_i,
    input  logic                occ12_i,
    input  logic                occ34_i,
    input  logic [NUM_DIRS-1:0] dir_req_i,
    input  logic                park12_i,
    output logic [NUM_DIRS-1:0] go_o,
    output logic [NUM_DIRS-1:0] stop_o,
    output logic                rotate_o,
    output logic                grant12_o,
    output logic                grant34_o
);
    logic [NUM_AXES-1:0] at_v, occ_v, want_v, grant_v;
    logic [NUM_DIRS-1:0] go_next;
    logic                coherent, rot_next;
    scan_out_t           q;

    always_comb begin
        at_v        = '0;
        occ_v       = '0;
        at_v[AX12]  = at12_i;
        at_v[AX34]  = at34_i;
        occ_v[AX12] = occ12_i;
        occ_v[AX34] = occ34_i;
    end

    assign want_v   = axis_wants(dir_req_i);
    assign coherent = inputs_coherent(at_v, occ_v);

    ilk_arbiter u_arb (
        .want     (want_v),
        .occ      (occ_v),
        .coherent (coherent),
        .grant    (grant_v)
    );

    ilk_light_gate u_lights (
        .at       (at_v),
        .occ      (occ_v),
        .grant    (grant_v),
        .coherent (coherent),
        .go       (go_next)
    );

    ilk_rotator u_rot (
        .occ      (occ_v),
        .grant    (grant_v),
        .coherent (coherent),
        .park12   (park12_i),
        .rot_q    (q.rotate),
        .rot_next (rot_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q.go     <= '0;
            q.stop   <= '1;
            q.rotate <= 1'b0;
            q.grant  <= '0;
        end else if (tick_i) begin
            q.go     <= go_next;
            q.stop   <= ~go_next;
            q.rotate <= rot_next;
            q.grant  <= grant_v;
        end
    end

    assign go_o      = q.go;
    assign stop_o    = q.stop;
    assign rotate_o  = q.rotate;
    assign grant12_o = q.grant[AX12];
    assign grant34_o = q.grant[AX34];

endmodule

// File: rtl/ilk_checker.sv
module ilk_checker (
    input logic       clk,
    input logic       rst,
    input logic       tick_i,
    input logic       at12_i,
    input logic       at34_i,
    input logic       occ12_i,
    input logic       occ34_i,
    input logic [3:0] dir_req_i,
    input logic       park12_i,
    input logic [3:0] go_o,
    input logic [3:0] stop_o,
    input logic       rotate_o,
    input logic       grant12_o,
    input logic       grant34_o
);
    logic ok_in;
    assign ok_in = !(at12_i && at34_i) && (!occ12_i || at12_i) && (!occ34_i || at34_i);

    assert_complement_R1: assert property (@(posedge clk) disable iff (rst)
        stop_o == ~go_o);

    assert_mirror_R2: assert property (@(posedge clk) disable iff (rst)
        (go_o[1] == go_o[0]) && (go_o[3] == go_o[2]));

    assert_gate12_R3: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> (!go_o[0] || ($past(at12_i) && ($past(occ12_i) || grant12_o))));

    assert_gate34_R3: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> (!go_o[2] || ($past(at34_i) && ($past(occ34_i) || grant34_o))));

    assert_no_double_green_R4: assert property (@(posedge clk) disable iff (rst)
        !(go_o[0] && go_o[2]));

    assert_occ_green_R5: assert property (@(posedge clk) disable iff (rst)
        (tick_i && ok_in && (occ12_i || occ34_i)) |=>
            ((!$past(occ12_i) || go_o[0]) && (!$past(occ34_i) || go_o[2])));

    assert_turn_R6: assert property (@(posedge clk) disable iff (rst)
        (tick_i && ok_in) |=> ((!grant12_o || rotate_o) && (!grant34_o || !rotate_o)));

    assert_grant_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(grant12_o && grant34_o));

    assert_priority_R8: assert property (@(posedge clk) disable iff (rst)
        (tick_i && ok_in && (dir_req_i[2] || dir_req_i[3]) && !occ12_i) |=> grant34_o);

    assert_park_R9: assert property (@(posedge clk) disable iff (rst)
        (tick_i && ok_in && dir_req_i == 4'b0 && !occ12_i && !occ34_i) |=>
            (rotate_o == $past(park12_i)));

    assert_incoherent_R11: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !ok_in) |=> (go_o == 4'b0 && !grant12_o && !grant34_o && $stable(rotate_o)));

    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> ($stable(go_o) && $stable(rotate_o) && $stable(grant12_o) && $stable(grant34_o)));

endmodule

bind ilk_crossing_ctrl ilk_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .at12_i    (at12_i),
    .at34_i    (at34_i),
    .occ12_i   (occ12_i),
    .occ34_i   (occ34_i),
    .dir_req_i (dir_req_i),
    .park12_i  (park12_i),
    .go_o      (go_o),
    .stop_o    (stop_o),
    .rotate_o  (rotate_o),
    .grant12_o (grant12_o),
    .grant34_o (grant34_o)
);

// File: tb/sim_ilk_crossing_ctrl.sv
module sim_ilk_crossing_ctrl;

    typedef struct packed {
        logic [3:0] go;
        logic [3:0] stop;
        logic       rot;
        logic       g12;
        logic       g34;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       at12_i = 1'b0, at34_i = 1'b0, occ12_i = 1'b0, occ34_i = 1'b0;
    logic [3:0] dir_req_i = 4'b0;
    logic       park12_i = 1'b0;
    logic [3:0] go_o, stop_o;
    logic       rotate_o, grant12_o, grant34_o;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];
    exp_t last_exp;
    logic model_rot = 1'b0;

    always #2 clk = ~clk;

    ilk_crossing_ctrl u0 (
        .clk(clk), .rst(rst), .tick_i(tick_i),
        .at12_i(at12_i), .at34_i(at34_i), .occ12_i(occ12_i), .occ34_i(occ34_i),
        .dir_req_i(dir_req_i), .park12_i(park12_i),
        .go_o(go_o), .stop_o(stop_o), .rotate_o(rotate_o),
        .grant12_o(grant12_o), .grant34_o(grant34_o)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model built from the requirement text
    function automatic exp_t model(logic a12, logic a34, logic o12, logic o34,
                                   logic [3:0] req, logic park, logic prev_rot);
        exp_t e;
        logic ok, w12, w34, gr12, gr34, gn12, gn34;
        ok  = !(a12 && a34) && (!o12 || a12) && (!o34 || a34);
        w12 = req[0] | req[1];
        w34 = req[2] | req[3];
        gr34 = ok && w34 && !o12;
        gr12 = ok && w12 && !o34 && !gr34;
        gn12 = ok && a12 && (gr12 || o12);
        gn34 = ok && a34 && (gr34 || o34);
        e.go   = {gn34, gn34, gn12, gn12};
        e.stop = ~e.go;
        e.g12  = gr12;
        e.g34  = gr34;
        if (!ok)              e.rot = prev_rot;
        else if (o12 || gr12) e.rot = 1'b1;
        else if (o34 || gr34) e.rot = 1'b0;
        else                  e.rot = park;
        return e;
    endfunction

    task automatic drive(logic [8:0] v);
        exp_t e;
        @(negedge clk);
        {at12_i, at34_i, occ12_i, occ34_i, dir_req_i, park12_i} = v;
        tick_i = 1'b1;
        e = model(v[8], v[7], v[6], v[5], v[4:1], v[0], model_rot);
        model_rot = e.rot;
        last_exp  = e;
        sb_q.push_back(e);
    endtask

    // monitor: one scoreboard item per ticked edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && tick_i) begin
                if (sb_q.size() == 0) begin
                    chk("R12 unexpected update", 8'd1, 8'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk("R3/R5/R10 green", {4'b0, go_o}, {4'b0, e.go});
                    chk("R1 red", {4'b0, stop_o}, {4'b0, e.stop});
                    chk("R6/R9/R11 rotate", {7'b0, rotate_o}, {7'b0, e.rot});
                    chk("R7/R8 grants", {6'b0, grant12_o, grant34_o}, {6'b0, e.g12, e.g34});
                    chk("R2 mirror", {6'b0, go_o[1], go_o[3]}, {6'b0, go_o[0], go_o[2]});
                    chk("R4 double green", {7'b0, go_o[0] & go_o[2]}, 8'd0);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R12 actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // reset with busy inputs and tick high: R13
        tick_i = 1'b1;
        at12_i = 1'b1; occ12_i = 1'b1; dir_req_i = 4'hF; park12_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R13 reset green", {4'b0, go_o}, 8'h00);
        chk("R13 reset red", {4'b0, stop_o}, 8'h0F);
        chk("R13 reset rotate", {7'b0, rotate_o}, 8'h00);
        chk("R13 reset grants", {6'b0, grant12_o, grant34_o}, 8'h00);
        tick_i = 1'b0;
        rst = 1'b0;

        // directed: 12 alone, then 34 joins (R8 priority), then 12 occupies
        drive({1'b1, 1'b0, 1'b0, 1'b0, 4'b0001, 1'b0});
        drive({1'b1, 1'b0, 1'b0, 1'b0, 4'b0101, 1'b0});
        drive({1'b1, 1'b0, 1'b1, 1'b0, 4'b1010, 1'b0});
        // R9 park both ways
        drive({1'b0, 1'b1, 1'b0, 1'b0, 4'b0000, 1'b1});
        drive({1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0});

        // exhaustive sweep, coherent and incoherent (R11)
        for (int i = 0; i < 512; i++) begin
            drive(9'(i));
        end
        for (int i = 511; i >= 0; i -= 7) begin
            drive(9'(i));
        end

        // R12: tick low, inputs change, outputs must hold
        @(negedge clk);
        tick_i = 1'b0;
        {at12_i, at34_i, occ12_i, occ34_i, dir_req_i, park12_i} =
            ~{last_exp.rot, last_exp.g12, last_exp.g34, 6'b010101};
        repeat (3) @(negedge clk);
        chk("R12 hold green", {4'b0, go_o}, {4'b0, last_exp.go});
        chk("R12 hold rotate", {7'b0, rotate_o}, {7'b0, last_exp.rot});
        chk("R12 hold grants", {6'b0, grant12_o, grant34_o}, {6'b0, last_exp.g12, last_exp.g34});

        repeat (3) @(negedge clk);
        chk("R12 scoreboard drained", 8'(sb_q.size()), 8'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule